// File: doc/BRIEF.md
# NAND Identification and Reset Command Responder

This block is the device side of a byte-wide NAND flash command interface, reduced to two operations: identification readout and reset. The chip-enable, command-latch, address-latch, write-strobe and read-strobe lines and the 8-bit input bus are brought into the system clock domain through a synchronizer. The block watches for write-strobe rising edges to latch command and address bytes. After the identification command and its single zero address byte, each read-strobe pulse presents the next byte of a five-byte identity string. The string is chosen by a configuration input.

A reset command puts the ready/busy output low for a fixed number of clock cycles and returns the interface to idle. A simulated busy operation can be started from a test input, and a reset command aborts it. A status byte reports write protection and readiness. While the block is busy, every command other than reset is ignored.

Top module: `nand_id_responder`

## Requirements
- R1: After power-on reset the interface is idle: `rb_n` is 1, `io_oe` is 0, and `status` is C0h when `wp_n` is 1.
- R2: Command 90h followed by an address byte of 00h enters identification mode, and the first read returns ECh.
- R3: In identification mode, successive read-strobe pulses return ECh, then the device code, then the third, fourth and fifth bytes. With `cfg_sel` 0/1/2/3 the device codes are ACh/A3h/BCh/B3h, the third bytes are 00h/01h/00h/01h, the fourth bytes are 15h/15h/55h/55h and the fifth bytes are 54h/58h/54h/58h.
- R4: Every read after the fifth byte returns 00h.
- R5: Identification mode persists across any number of reads until a new command byte is latched. A repeated 90h/00h restarts at ECh, and any other command leaves the mode, so that `io_oe` stays 0.
- R6: Command 90h followed by a nonzero address byte does not enter identification mode.
- R7: A reset command (FFh) drives `rb_n` low for exactly RST_CYCLES clock cycles, after which it returns high.
- R8: A reset command issued during a simulated busy operation aborts it, and `rb_n` rises RST_CYCLES cycles after the reset rather than at the end of the operation.
- R9: `status` bit 7 follows `wp_n` and bit 6 is 1 when ready and 0 when busy; all other bits are 0 (C0h, 40h with `wp_n` low, 80h while busy).
- R10: While busy, command and address bytes other than FFh are ignored.
- R11: A reset command is accepted while a reset interval is already running, and it restarts the full interval.
- R12: Bytes are latched only while `ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_sel | input | 2 | Identity selection: 0 4Gb x8, 1 8Gb dual-die x8, 2 4Gb x16, 3 8Gb dual-die x16 |
| wp_n | input | 1 | Write-protect line, active low |
| busy_inject | input | 1 | Test input: a one-cycle pulse starts a simulated busy operation if ready |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; bytes latched on its rising edge |
| re_n | input | 1 | Read strobe; byte index advances on its rising edge |
| io_in | input | 8 | Input data bus |
| io_out | output | 8 | Output data bus |
| io_oe | output | 1 | Output enable for io_out |
| rb_n | output | 1 | Ready (1) / busy (0) |
| status | output | 8 | Status byte |

## Verification
The bench sets RST_CYCLES to 16 and OP_CYCLES to 300. The short reset interval lets the bench latch a second reset command before the first interval has ended, which exercises the restart. The simulated operation is long enough that an abort is clearly visible in the measured busy width, and it leaves time to issue identification bytes that must be ignored while busy. All four identity selections are walked, including reads past the end of the string.

// File: rtl/nand_id_pkg.sv
package nand_id_pkg;
  localparam logic [7:0] CMD_READ_ID = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] ADDR_ID     = 8'h00;
  localparam logic [7:0] MAKER_CODE  = 8'hEC;
  localparam int         ID_LEN      = 5;
  localparam int         IDX_W       = $clog2(ID_LEN + 1);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ID_ADDR = 2'd1,
    ST_ID_OUT  = 2'd2
  } if_state_t;

  // cfg[0]: dual-die, cfg[1]: x16 width
  function automatic logic [7:0] id_byte(input logic [1:0] cfg, input logic [IDX_W-1:0] idx);
    logic dual;
    logic wide;
    dual = cfg[0];
    wide = cfg[1];
    case (idx)
      0:       id_byte = MAKER_CODE;
      1:       id_byte = {(wide ? 4'hB : 4'hA), (dual ? 4'h3 : 4'hC)};
      2:       id_byte = {7'd0, dual};
      3:       id_byte = wide ? 8'h55 : 8'h15;
      4:       id_byte = dual ? 8'h58 : 8'h54;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/nand_strobe_sync.sv
module nand_strobe_sync #(
  parameter int           W       = 13,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= RST_VAL;
          else        pipe[g] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= RST_VAL;
          else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int RST_CYCLES = 250,
  parameter int OP_CYCLES  = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_cmd,
  input  logic op_start,
  output logic busy,
  output logic op_load_ev
);
  localparam int MAXV = (RST_CYCLES > OP_CYCLES) ? RST_CYCLES : OP_CYCLES;
  localparam int CW   = $clog2(MAXV + 1);

  logic [CW-1:0] cnt;

  assign busy       = (cnt != '0);
  assign op_load_ev = op_start && !busy && !rst_cmd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (rst_cmd)    cnt <= CW'(RST_CYCLES);
    else if (op_load_ev) cnt <= CW'(OP_CYCLES);
    else if (busy)       cnt <= cnt - 1'b1;
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_sel,
  input  logic             ce_n_s,
  input  logic             cle_s,
  input  logic             ale_s,
  input  logic             we_n_s,
  input  logic             re_n_s,
  input  logic [7:0]       io_s,
  input  logic             busy,
  output logic             rst_cmd_ev,
  output logic             id_mode,
  output logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       io_out,
  output logic             io_oe
);
  if_state_t state;
  logic      we_prev, re_prev;
  logic      we_rise, re_rise, latch_ok;
  logic      cmd_ev, addr_ev, accept_cmd, accept_addr;

  assign we_rise     = we_n_s && !we_prev;
  assign re_rise     = re_n_s && !re_prev;
  assign latch_ok    = we_rise && !ce_n_s;
  assign cmd_ev      = latch_ok && cle_s && !ale_s;
  assign addr_ev     = latch_ok && ale_s && !cle_s;
  assign rst_cmd_ev  = cmd_ev && (io_s == CMD_RESET);
  assign accept_cmd  = cmd_ev && (!busy || rst_cmd_ev);
  assign accept_addr = addr_ev && !busy && (state == ST_ID_ADDR);
  assign id_mode     = (state == ST_ID_OUT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      we_prev <= 1'b1;
      re_prev <= 1'b1;
    end else begin
      we_prev <= we_n_s;
      re_prev <= re_n_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= ST_IDLE;
      rd_idx <= '0;
    end else if (accept_cmd) begin
      state <= (io_s == CMD_READ_ID) ? ST_ID_ADDR : ST_IDLE;
    end else if (accept_addr) begin
      state  <= (io_s == ADDR_ID) ? ST_ID_OUT : ST_IDLE;
      rd_idx <= '0;
    end else if (id_mode && re_rise && !ce_n_s && (rd_idx < IDX_W'(ID_LEN))) begin
      rd_idx <= rd_idx + 1'b1;
    end

  assign io_oe  = id_mode && !re_n_s && !ce_n_s && !busy;
  assign io_out = io_oe ? id_byte(cfg_sel, rd_idx) : 8'h00;
endmodule

// File: rtl/nand_id_responder.sv
module nand_id_responder
  import nand_id_pkg::*;
#(
  parameter int RST_CYCLES  = 250,
  parameter int OP_CYCLES   = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_sel,
  input  logic       wp_n,
  input  logic       busy_inject,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb_n,
  output logic [7:0] status
);
  localparam int            SW      = 13;
  localparam logic [SW-1:0] SYNC_RV = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00};

  logic [SW-1:0]    raw_bus, sync_bus;
  logic             ce_n_s, cle_s, ale_s, we_n_s, re_n_s;
  logic [7:0]       io_s;
  logic             busy, rst_cmd_ev, op_load_ev, id_mode;
  logic [IDX_W-1:0] rd_idx;

  assign raw_bus = {ce_n, cle, ale, we_n, re_n, io_in};

  nand_strobe_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RV)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_bus), .d_out(sync_bus)
  );

  assign {ce_n_s, cle_s, ale_s, we_n_s, re_n_s, io_s} = sync_bus;

  nand_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
    .ce_n_s(ce_n_s), .cle_s(cle_s), .ale_s(ale_s), .we_n_s(we_n_s), .re_n_s(re_n_s),
    .io_s(io_s), .busy(busy), .rst_cmd_ev(rst_cmd_ev), .id_mode(id_mode),
    .rd_idx(rd_idx), .io_out(io_out), .io_oe(io_oe)
  );

  nand_busy_timer #(.RST_CYCLES(RST_CYCLES), .OP_CYCLES(OP_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .rst_cmd(rst_cmd_ev), .op_start(busy_inject),
    .busy(busy), .op_load_ev(op_load_ev)
  );

  assign rb_n   = !busy;
  assign status = {wp_n, !busy, 6'b000000};
endmodule

// File: rtl/nand_id_responder_chk.sv
module nand_id_responder_chk #(
  parameter int RST_CYCLES = 250,
  parameter int IDX_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rb_n,
  input logic [7:0]       status,
  input logic             wp_n,
  input logic             io_oe,
  input logic [7:0]       io_out,
  input logic             id_mode,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rst_cmd_ev,
  input logic             op_load_ev
);
  logic [31:0] since_rst;
  logic        last_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      since_rst <= '0;
      last_rst  <= 1'b0;
    end else begin
      if (rst_cmd_ev)                since_rst <= 32'd1;
      else if (since_rst != '1)      since_rst <= since_rst + 1'b1;
      if (rst_cmd_ev)                last_rst  <= 1'b1;
      else if (op_load_ev)           last_rst  <= 1'b0;
    end

  // R7
  rst_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_ev |=> !rb_n);

  // R7
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rb_n) && last_rst) |-> (since_rst == 32'(RST_CYCLES + 1)));

  // R9
  status_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_n |-> (status[6] == 1'b0 && status[7] == wp_n && status[5:0] == 6'd0));

  // R10
  busy_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_n && !rst_cmd_ev) |=> $stable(id_mode));

  // R4
  past_end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && rd_idx >= IDX_W'(5)) |-> (io_out == 8'h00));

  // R2
  oe_only_in_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> id_mode);

  // R2
  id_entry_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> (rd_idx == '0));
endmodule

bind nand_id_responder nand_id_responder_chk #(.RST_CYCLES(RST_CYCLES), .IDX_W(nand_id_pkg::IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .status(status), .wp_n(wp_n),
  .io_oe(io_oe), .io_out(io_out), .id_mode(id_mode), .rd_idx(rd_idx),
  .rst_cmd_ev(rst_cmd_ev), .op_load_ev(op_load_ev)
);

// File: tb/test_nand_id_responder.sv
module test_nand_id_responder;
  localparam int RST_CYC = 16;
  localparam int OP_CYC  = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic       wp_n = 1'b1;
  logic       busy_inject = 1'b0;
  logic       ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic       io_oe;
  logic       rb_n;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  int low_run  = 0;
  int last_run = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  nand_id_responder #(.RST_CYCLES(RST_CYC), .OP_CYCLES(OP_CYC)) i_nand_id_responder (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .wp_n(wp_n), .busy_inject(busy_inject),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_id(input int c, input int n);
    logic [7:0] dev[4] = '{8'hAC, 8'hA3, 8'hBC, 8'hB3};
    logic [7:0] b3[4]  = '{8'h00, 8'h01, 8'h00, 8'h01};
    logic [7:0] b4[4]  = '{8'h15, 8'h15, 8'h55, 8'h55};
    logic [7:0] b5[4]  = '{8'h54, 8'h58, 8'h54, 8'h58};
    case (n)
      0: return 8'hEC;
      1: return dev[c];
      2: return b3[c];
      3: return b4[c];
      4: return b5[c];
      default: return 8'h00;
    endcase
  endfunction

  // monitor: pop one expectation per output-enable window
  always @(negedge clk) begin
    if (rst_n && io_oe && !oe_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "unexpected-read", io_out, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(io_out == e, t, io_out, e);
      end
    end
    oe_prev = io_oe;
    if (!rb_n) low_run++;
    else if (low_run != 0) begin
      last_run = low_run;
      low_run  = 0;
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_byte(input bit is_cmd, input logic [7:0] d, input bit ce_hi = 1'b0);
    cle = is_cmd; ale = !is_cmd; io_in = d; ce_n = ce_hi;
    waitc(1);
    we_n = 1'b0; waitc(4);
    we_n = 1'b1; waitc(4);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
    waitc(2);
  endtask

  task automatic read_expect(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    ce_n = 1'b0; re_n = 1'b0; waitc(5);
    re_n = 1'b1; waitc(5);
    ce_n = 1'b1; waitc(1);
  endtask

  task automatic read_none(input string tag);
    ce_n = 1'b0; re_n = 1'b0; waitc(4);
    @(negedge clk);
    chk(io_oe == 1'b0, tag, io_oe, 0);
    waitc(1);
    re_n = 1'b1; waitc(5);
    ce_n = 1'b1; waitc(1);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rb_n && n < 2000) begin
      waitc(1);
      n++;
    end
  endtask

  task automatic pulse_inject();
    busy_inject = 1'b1; waitc(1);
    busy_inject = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);

    // R1
    chk(rb_n == 1'b1, "R1 rb_n", rb_n, 1);
    chk(io_oe == 1'b0, "R1 io_oe", io_oe, 0);
    chk(status == 8'hC0, "R1 status", status, 8'hC0);

    // R2 R3 R4 across all four selections
    for (int c = 0; c < 4; c++) begin
      cfg_sel = 2'(c);
      write_byte(1'b1, 8'h90);
      write_byte(1'b0, 8'h00);
      read_expect(ref_id(c, 0), "R2 maker");
      for (int k = 1; k < 5; k++) read_expect(ref_id(c, k), $sformatf("R3 cfg%0d byte%0d", c, k));
      read_expect(8'h00, "R4 past end");
      read_expect(8'h00, "R4 past end again");
    end

    // R5: restart, then exit on another command
    write_byte(1'b1, 8'h90);
    write_byte(1'b0, 8'h00);
    read_expect(8'hEC, "R5 restart maker");
    read_expect(ref_id(3, 1), "R5 persists");
    write_byte(1'b1, 8'h00);
    read_none("R5 exit on new command");

    // R6
    write_byte(1'b1, 8'h90);
    write_byte(1'b0, 8'h01);
    read_none("R6 nonzero address");

    // R12
    write_byte(1'b1, 8'h90, 1'b1);
    write_byte(1'b0, 8'h00);
    read_none("R12 ce high ignored");

    // R9
    wp_n = 1'b0; waitc(2);
    chk(status == 8'h40, "R9 wp low", status, 8'h40);
    wp_n = 1'b1; waitc(2);

    // R7
    write_byte(1'b1, 8'hFF);
    chk(rb_n == 1'b0, "R7 busy after reset", rb_n, 0);
    chk(status == 8'h80, "R9 busy status", status, 8'h80);
    wait_ready(n);
    waitc(2);
    chk(last_run == RST_CYC, "R7 busy width", last_run, RST_CYC);

    // R8
    pulse_inject();
    waitc(20);
    chk(rb_n == 1'b0, "R8 op busy", rb_n, 0);
    write_byte(1'b1, 8'hFF);
    wait_ready(n);
    chk(n <= RST_CYC, "R8 ready after reset", n, RST_CYC);
    waitc(2);
    chk(last_run < OP_CYC, "R8 op aborted", last_run, OP_CYC);

    // R11
    write_byte(1'b1, 8'hFF);
    write_byte(1'b1, 8'hFF);
    chk(rb_n == 1'b0, "R11 still busy", rb_n, 0);
    wait_ready(n);
    waitc(2);
    chk(last_run > RST_CYC, "R11 interval restarted", last_run, RST_CYC);

    // R10
    pulse_inject();
    waitc(3);
    write_byte(1'b1, 8'h90);
    write_byte(1'b0, 8'h00);
    wait_ready(n);
    waitc(2);
    read_none("R10 command ignored while busy");

    waitc(5);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule